// File: doc/BRIEF.md
# Manchester Line Decoder

This block recovers data bits from a serial line carrying Manchester-coded packets. The line is sampled once per clock and every data bit occupies two clock periods, so each half-bit is exactly one sample. A low-to-high pair carries a one and a high-to-low pair carries a zero. Between packets the line rests high, and every packet opens with a zero bit.

The decoder is a Moore state machine. It waits on the high idle line and takes the first falling transition as the second half of the opening zero bit. That choice fixes the half-bit phase, and from then on samples are paired on it. Each completed pair produces a one-clock pulse on the valid output with the decoded bit beside it. A high-high pair means the line has gone idle, and the machine goes back to waiting. A low-low pair is a coding violation. After a violation the decoder stays silent until the line has shown two high samples in a row.

Top module: `manchester_decoder`

## Requirements
- R1: While the synchronous reset is high, and in the cycle after it, `valid_out` and `data_out` are 0. The machine starts in a waiting state in which low samples start nothing until at least one high sample has been seen.
- R2: A bit sent as sample 0 then sample 1 decodes to `data_out`=1. A bit sent as sample 1 then sample 0 decodes to `data_out`=0.
- R3: In the waiting state, after a high sample, a low sample is taken as the second half of the opening zero bit. `valid_out`=1 with `data_out`=0 is produced for it.
- R4: After the opening bit, samples are paired on the phase set in R3. `valid_out` is 1 for exactly the one clock that follows the edge capturing a pair's second sample, and 0 after the first sample of each pair. `data_out` is 0 whenever `valid_out` is 0.
- R5: A pair of two high samples ends the packet with no pulse. The machine returns to waiting, where the next high-then-low pair starts a new packet.
- R6: A pair of two low samples is a coding violation. It produces no pulse, and the machine enters an error state in which `valid_out` stays 0, however long the line stays low.
- R7: From the error state the machine goes back to waiting only after two consecutive high samples. A high-low pattern seen before that produces no pulse.
- R8: `valid_out` is never 1 in two consecutive clocks. It is never 1 in the cycle after two consecutive high samples have been captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, two periods per data bit |
| rst | input | 1 | Synchronous reset, active high |
| line_in | input | 1 | Manchester-coded serial line, one sample per clock |
| data_out | output | 1 | Decoded bit, qualified by `valid_out` |
| valid_out | output | 1 | One-clock pulse per decoded bit |

## Verification
The assertions assume that `line_in` is already synchronous to `clk` and carries exactly one sample per half-bit. They do not cover a line that drifts against the clock or is oversampled. The stimulus respects this by changing `line_in` only on the falling clock edge, once per cycle. It sweeps every 8-bit payload with varying idle gaps, and injects low-low violations at every early bit position followed by long low runs. Before the line shows the two high samples that re-arm the decoder, the stimulus also sends high-low patterns that resemble a packet start.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

    // Decoder states. Eight states fill the 3-bit code space.
    typedef enum logic [2:0] {
        ST_WAIT_LO = 3'd0,  // waiting, no high sample seen yet
        ST_WAIT_HI = 3'd1,  // waiting, last sample high
        ST_EMIT_0  = 3'd2,  // second half just taken, bit was 0
        ST_EMIT_1  = 3'd3,  // second half just taken, bit was 1
        ST_HALF_HI = 3'd4,  // first half of a pair was high
        ST_HALF_LO = 3'd5,  // first half of a pair was low
        ST_ERR_LO  = 3'd6,  // violation seen, last sample low
        ST_ERR_HI  = 3'd7   // violation seen, one high sample so far
    } dstate_e;

    typedef struct packed {
        logic valid;
        logic data;
    } dout_t;

    localparam dout_t DOUT_IDLE = '{valid: 1'b0, data: 1'b0};

    // Transition function of the decoder.
    function automatic dstate_e step_state(input dstate_e cur, input logic smp);
        dstate_e nxt;
        unique case (cur)
            ST_WAIT_LO: nxt = smp ? ST_WAIT_HI : ST_WAIT_LO;
            ST_WAIT_HI: nxt = smp ? ST_WAIT_HI : ST_EMIT_0;
            ST_EMIT_0,
            ST_EMIT_1:  nxt = smp ? ST_HALF_HI : ST_HALF_LO;
            ST_HALF_HI: nxt = smp ? ST_WAIT_HI : ST_EMIT_0;
            ST_HALF_LO: nxt = smp ? ST_EMIT_1  : ST_ERR_LO;
            ST_ERR_LO:  nxt = smp ? ST_ERR_HI  : ST_ERR_LO;
            ST_ERR_HI:  nxt = smp ? ST_WAIT_HI : ST_ERR_LO;
            default:    nxt = ST_WAIT_LO;
        endcase
        return nxt;
    endfunction

    // Moore output decode.
    function automatic dout_t state_out(input dstate_e st);
        dout_t o;
        o = DOUT_IDLE;
        if (st == ST_EMIT_0) begin
            o.valid = 1'b1;
            o.data  = 1'b0;
        end else if (st == ST_EMIT_1) begin
            o.valid = 1'b1;
            o.data  = 1'b1;
        end
        return o;
    endfunction

    function automatic logic is_error(input dstate_e st);
        return (st == ST_ERR_LO) || (st == ST_ERR_HI);
    endfunction

endpackage

// File: rtl/mdec_fsm.sv
module mdec_fsm
    import mdec_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    smp,
    output dstate_e state_q,
    output dstate_e state_d
);

    always_comb begin
        state_d = step_state(state_q, smp);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_WAIT_LO;
        end else begin
            state_q <= state_d;
        end
    end

    // R3
    lead_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT_HI && !smp) |=> (state_q == ST_EMIT_0));

    // R7
    err_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ERR_LO) |=> (state_q == ST_ERR_LO || state_q == ST_ERR_HI));

endmodule

// File: rtl/mdec_outreg.sv
module mdec_outreg
    import mdec_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  dstate_e state_d,
    output logic    valid_q,
    output logic    data_q
);

    dout_t nxt_out;

    always_comb begin
        nxt_out = state_out(state_d);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            data_q  <= 1'b0;
        end else begin
            valid_q <= nxt_out.valid;
            data_q  <= nxt_out.data;
        end
    end

    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q);

    // R4
    data_qual_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_q |-> !data_q);

endmodule

// File: rtl/manchester_decoder.sv
module manchester_decoder
    import mdec_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic data_out,
    output logic valid_out
);

    dstate_e state_q;
    dstate_e state_d;

    mdec_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .smp     (line_in),
        .state_q (state_q),
        .state_d (state_d)
    );

    mdec_outreg u_out (
        .clk     (clk),
        .rst     (rst),
        .state_d (state_d),
        .valid_q (valid_out),
        .data_q  (data_out)
    );

    // R6
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        is_error(state_q) |-> !valid_out);

    // R8
    high_pair_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(line_in) && line_in) |=> !valid_out);

    // R3
    lead_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT_HI && !line_in) |=> (valid_out && !data_out));

    // R1
    reset_out_chk: assert property (@(posedge clk)
        rst |=> (!valid_out && !data_out));

endmodule

// File: tb/test_manchester_decoder.sv
module test_manchester_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_in = 1'b1;
    logic data_out;
    logic valid_out;

    int vectors = 0;
    int misses = 0;

    manchester_decoder i_manchester_decoder (
        .clk       (clk),
        .rst       (rst),
        .line_in   (line_in),
        .data_out  (data_out),
        .valid_out (valid_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input logic ev, input logic ed, input string req);
        vectors++;
        if (valid_out !== ev || data_out !== ed) begin
            misses++;
            $display("FAIL %s: valid=%b data=%b expected valid=%b data=%b at %0t",
                     req, valid_out, data_out, ev, ed, $time);
        end
    endtask

    // Called at a falling edge: drive one sample, wait one cycle, compare.
    task automatic step(input logic s, input logic ev, input logic ed, input string req);
        line_in = s;
        @(negedge clk);
        check(ev, ed, req);
    endtask

    task automatic do_reset(input logic lvl);
        rst = 1'b1;
        line_in = lvl;
        @(negedge clk);
        check(1'b0, 1'b0, "R1 during reset");
        rst = 1'b0;
    endtask

    // Encode one bit: zero = 1,0 ; one = 0,1. Pulse after second half.
    task automatic send_bit(input logic b, input string req);
        step(~b, 1'b0, 1'b0, "R4 first half");
        step(b, 1'b1, b, req);
    endtask

    task automatic seq(input logic [31:0] e, input logic [31:0] v,
                       input logic [31:0] d, input int n, input string req);
        for (int i = n - 1; i >= 0; i--) begin
            step(e[i], v[i], d[i], req);
        end
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG_CYCLES);
        misses++;
        $display("FAIL watchdog: run did not complete, expected finish");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset(1'b1);

        // Payload sweep: every 8-bit word, varying idle gaps.
        for (int w = 0; w < 256; w++) begin
            for (int k = 0; k < (w % 4); k++) begin
                step(1'b1, 1'b0, 1'b0, "R5 idle high");
            end
            send_bit(1'b0, "R3 opening zero");
            for (int j = 7; j >= 0; j--) begin
                send_bit(w[j], "R2 payload bit");
            end
            step(1'b1, 1'b0, 1'b0, "R5 end pair first");
            step(1'b1, 1'b0, 1'b0, "R5 end pair second");
        end

        // Violation sweep: 00 pair after 0..3 bits, long low runs, fake starts.
        for (int w = 0; w < 64; w++) begin
            do_reset(w[0]);
            step(1'b1, 1'b0, 1'b0, "R1 first high");
            step(1'b0, 1'b1, 1'b0, "R3 opening zero");
            for (int j = 0; j < (w % 4); j++) begin
                send_bit(w[j + 2], "R2 bit before violation");
            end
            step(1'b0, 1'b0, 1'b0, "R6 violation first");
            step(1'b0, 1'b0, 1'b0, "R6 violation second");
            for (int k = 0; k < (w / 8); k++) begin
                step(1'b0, 1'b0, 1'b0, "R6 long low run");
            end
            step(1'b1, 1'b0, 1'b0, "R7 single high");
            step(1'b0, 1'b0, 1'b0, "R7 fake start");
            step(1'b1, 1'b0, 1'b0, "R7 single high");
            step(1'b0, 1'b0, 1'b0, "R7 fake start");
            step(1'b1, 1'b0, 1'b0, "R7 first of two highs");
            step(1'b1, 1'b0, 1'b0, "R7 second of two highs");
            step(1'b0, 1'b1, 1'b0, "R7 rearmed opening zero");
            send_bit(w[1], "R2 bit after recovery");
            step(1'b1, 1'b0, 1'b0, "R5 end pair first");
            step(1'b1, 1'b0, 1'b0, "R5 end pair second");
        end

        // Directed: violation, partial recovery, re-arm, bits.
        do_reset(1'b1);
        seq(32'(18'b110010010101100111), 32'(18'b001010000000010100),
            32'(18'b000010000000000100), 18, "R7 directed");

        // Directed: reset mid-packet, then low line must not start a packet.
        do_reset(1'b1);
        seq(32'(4'b1100), 32'(4'b0010), 32'(4'b0000), 4, "R3 before reset");
        do_reset(1'b0);
        seq(32'(11'b00010101110), 32'(11'b00001010001),
            32'(11'b00000000000), 11, "R1 low line after reset");

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule